// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block gathers every reason to stop a three-phase PWM power stage and turns them into one force-off command. That command drives all six gate outputs to their off level and holds the PWM timing counter in reset. There are three kinds of request. The first is an active-low trip pin. The second is a digital overcurrent flag from an external comparator. The third is a one-cycle software halt strobe that a register write produces.

The two hardware requests act asynchronously. They reach the force-off output through combinational logic and an asynchronously set holding flop. The stage is therefore shut down even when no clock is running, and it stays shut down after the pin or flag returns to idle.

A two-state machine runs on the clock. Its states are ST_RUN and ST_HALT. Transition T_EVENT moves ST_RUN to ST_HALT on any shutdown event. Transition T_CLEAR moves ST_HALT back to ST_RUN on an accepted software clear. The hardware requests reach the machine through a two-flop synchronizer. The machine raises a one-cycle interrupt strobe for each new shutdown event and records which source caused the latest one.

Top module: `pwm_shutdown_ctrl`

## Requirements
- R1: While `trip_n` is low, `force_off` and `tmr_rst` are 1 with no clock edge needed, including while the clock is stopped.
- R2: While `ovc_flag` is high, `force_off` and `tmr_rst` are 1 with no clock edge needed.
- R3: A one-cycle `sw_halt_wr` pulse sets `force_off` from the next rising clock edge. The machine moves ST_RUN to ST_HALT by T_EVENT.
- R4: Once set by any source, `force_off` stays 1 after every source has returned to idle, until a clear is accepted.
- R5: A `sw_clear_wr` pulse is accepted only when both synchronized hardware sources are idle. On acceptance, `force_off` is 0 after that edge and the machine takes T_CLEAR to ST_RUN. Otherwise the clear has no effect.
- R6: `sd_irq` is high for exactly one cycle per new event. For a pin or flag assertion, it is high after the third rising edge following the change. A software halt raises it after the first edge. A source that is held active raises it only once. A new event raises it again even in ST_HALT.
- R7: `sd_cause` encodes the latest cause: 2'b01 trip pin, 2'b10 overcurrent, 2'b11 software. Its reset value is 2'b00. When events coincide, the priority is trip > overcurrent > software. The value is kept after a clear.
- R8: `trip_lvl` shows the `trip_n` level two rising edges late and reads 1 after reset.
- R9: A `sw_clear_wr` that falls in the same cycle as a new shutdown event is ignored, and the block stays in ST_HALT.
- R10: After reset with all sources idle, `force_off`, `tmr_rst` and `sd_irq` are 0 and `sd_cause` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_n | input | 1 | External trip request, active low, asynchronous |
| ovc_flag | input | 1 | Overcurrent comparator result, active high, asynchronous |
| sw_halt_wr | input | 1 | One-cycle software shutdown write strobe |
| sw_clear_wr | input | 1 | One-cycle software clear write strobe |
| force_off | output | 1 | Drives all six PWM outputs to off |
| tmr_rst | output | 1 | Holds the PWM timing counter in reset |
| sd_irq | output | 1 | One-cycle shutdown interrupt strobe |
| sd_cause | output | 2 | Source of the latest shutdown |
| trip_lvl | output | 1 | Synchronized trip pin level |

## Verification
Two functions can land in the same clock edge. One is a software clear. The other is a new shutdown event, either a software halt or a synchronized hardware assertion. The bench drives `sw_clear_wr` and `sw_halt_wr` together while halted. It then times a trip-pin fall so that its synchronized edge meets a software halt in the same cycle. In the first case, the bench judges that `force_off` stays set and an interrupt is raised. In the second, it judges that exactly one interrupt appears and that it reports the trip-pin cause.

// File: rtl/pwm_sd_pkg.sv
`timescale 1ns/1ps
package pwm_sd_pkg;
    localparam int NUM_HW_SRC = 2;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } sd_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_TRIP = 2'b01,
        CAUSE_OVC  = 2'b10,
        CAUSE_SW   = 2'b11
    } sd_cause_t;
endpackage

// File: rtl/pwm_sd_sync.sv
`timescale 1ns/1ps
module pwm_sd_sync #(
    parameter int W = 2,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwm_sd_hold.sv
`timescale 1ns/1ps
module pwm_sd_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_async,
    input  logic clr_sync,
    output logic hold_q
);
    // The asynchronous set outranks reset, so a source that is held
    // active through reset keeps the stage off.
    always_ff @(posedge clk or posedge set_async or negedge rst_n) begin
        if (set_async)   hold_q <= 1'b1;
        else if (!rst_n) hold_q <= 1'b0;
        else if (clr_sync) hold_q <= 1'b0;
    end

    AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_async |-> hold_q); // R1
endmodule

// File: rtl/pwm_sd_fsm.sv
`timescale 1ns/1ps
module pwm_sd_fsm
    import pwm_sd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_s,
    input  logic       ovc_s,
    input  logic       sw_halt_wr,
    input  logic       sw_clear_wr,
    output logic       halted,
    output logic       irq,
    output logic [1:0] cause,
    output logic       clr_ok
);
    sd_state_t state_q, state_d;
    sd_cause_t cause_q, cause_d;
    logic      irq_q;
    logic      trip_d, ovc_d;
    logic      evt_trip, evt_ovc, evt_any;

    assign evt_trip = trip_s & ~trip_d;
    assign evt_ovc  = ovc_s & ~ovc_d;
    assign evt_any  = evt_trip | evt_ovc | sw_halt_wr;
    assign clr_ok   = sw_clear_wr & ~trip_s & ~ovc_s & ~evt_any;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (evt_any) state_d = ST_HALT;  // T_EVENT
            ST_HALT: if (clr_ok)  state_d = ST_RUN;   // T_CLEAR
        endcase
    end

    always_comb begin
        if (evt_trip)        cause_d = CAUSE_TRIP;
        else if (evt_ovc)    cause_d = CAUSE_OVC;
        else if (sw_halt_wr) cause_d = CAUSE_SW;
        else                 cause_d = cause_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
            trip_d  <= 1'b0;
            ovc_d   <= 1'b0;
        end else begin
            irq_q   <= evt_any;
            cause_q <= cause_d;
            trip_d  <= trip_s;
            ovc_d   <= ovc_s;
        end
    end

    assign halted = (state_q == ST_HALT);
    assign irq    = irq_q;
    assign cause  = cause_q;

    AST_SW_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_halt_wr |=> state_q == ST_HALT); // R3
    AST_CLR_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_HALT) |-> $past(sw_clear_wr && !trip_s && !ovc_s)); // R5
    AST_IRQ_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> state_q == ST_HALT); // R6
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> cause_q != CAUSE_NONE); // R7
    AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && sw_clear_wr && sw_halt_wr) |=> state_q == ST_HALT); // R9
endmodule

// File: rtl/pwm_shutdown_ctrl.sv
`timescale 1ns/1ps
module pwm_shutdown_ctrl
    import pwm_sd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip_n,
    input  logic       ovc_flag,
    input  logic       sw_halt_wr,
    input  logic       sw_clear_wr,
    output logic       force_off,
    output logic       tmr_rst,
    output logic       sd_irq,
    output logic [1:0] sd_cause,
    output logic       trip_lvl
);
    logic                  hw_raw;
    logic [NUM_HW_SRC-1:0] flt_raw, flt_s;
    logic                  hold_q, halted, clr_ok;

    assign flt_raw = {ovc_flag, ~trip_n};
    assign hw_raw  = |flt_raw;

    pwm_sd_sync #(.W(NUM_HW_SRC), .STAGES(SYNC_DEPTH), .RST_VAL('0)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(flt_raw), .q(flt_s)
    );

    pwm_sd_hold u_hold (
        .clk(clk), .rst_n(rst_n), .set_async(hw_raw),
        .clr_sync(clr_ok), .hold_q(hold_q)
    );

    pwm_sd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trip_s(flt_s[0]), .ovc_s(flt_s[1]),
        .sw_halt_wr(sw_halt_wr), .sw_clear_wr(sw_clear_wr),
        .halted(halted), .irq(sd_irq), .cause(sd_cause), .clr_ok(clr_ok)
    );

    assign force_off = hw_raw | hold_q | halted;
    assign tmr_rst   = force_off;
    assign trip_lvl  = ~flt_s[0];

    AST_SYNC_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        (|flt_s) |-> force_off); // R2
    AST_SW_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_halt_wr |=> force_off); // R3
    AST_STAY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (force_off && !sw_clear_wr) |=> force_off); // R4
endmodule

// File: tb/sim_pwm_shutdown_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_shutdown_ctrl;
    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic rst_n = 1'b0;
    logic trip_n = 1'b1, ovc_flag = 1'b0, sw_halt_wr = 1'b0, sw_clear_wr = 1'b0;
    logic force_off, tmr_rst, sd_irq, trip_lvl;
    logic [1:0] sd_cause;
    int checks = 0, errors = 0;
    bit done = 0;

    pwm_shutdown_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .ovc_flag(ovc_flag),
        .sw_halt_wr(sw_halt_wr), .sw_clear_wr(sw_clear_wr),
        .force_off(force_off), .tmr_rst(tmr_rst), .sd_irq(sd_irq),
        .sd_cause(sd_cause), .trip_lvl(trip_lvl)
    );

    initial forever begin
        #2;
        if (clk_run) clk = ~clk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_clear();
        sw_clear_wr = 1'b1; tick(); sw_clear_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "force_off", force_off, 0);
        chk("R10", "tmr_rst", tmr_rst, 0);
        chk("R10", "irq", sd_irq, 0);
        chk("R10", "cause", sd_cause, 0);
        chk("R8", "trip_lvl reset", trip_lvl, 1);
    endtask

    task automatic t_stopped_clock();
        clk_run = 1'b0; #10;
        trip_n = 1'b0; #1;
        chk("R1", "force_off no clock", force_off, 1);
        chk("R1", "tmr_rst no clock", tmr_rst, 1);
        trip_n = 1'b1; #5;
        chk("R4", "held after pulse", force_off, 1);
        clk_run = 1'b1;
        tick(4);
        chk("R4", "held with clock", force_off, 1);
        do_clear();
        chk("R5", "clear after glitch", force_off, 0);
    endtask

    task automatic t_trip();
        trip_n = 1'b0; #0.5;
        chk("R1", "immediate force_off", force_off, 1);
        #0.5;
        tick(2);
        chk("R6", "irq after 2 edges", sd_irq, 0);
        chk("R8", "trip_lvl after 2 edges", trip_lvl, 0);
        tick();
        chk("R6", "irq after 3rd edge", sd_irq, 1);
        chk("R7", "cause trip", sd_cause, 1);
        tick();
        chk("R6", "irq one cycle", sd_irq, 0);
        tick(2);
        chk("R6", "no repeat irq while held", sd_irq, 0);
        do_clear();
        chk("R5", "clear refused while low", force_off, 1);
        trip_n = 1'b1;
        tick(2);
        chk("R4", "held after release", force_off, 1);
        chk("R8", "trip_lvl back high", trip_lvl, 1);
        do_clear();
        chk("R5", "clear accepted", force_off, 0);
        chk("R7", "cause kept after clear", sd_cause, 1);
    endtask

    task automatic t_ovc();
        ovc_flag = 1'b1; #0.5;
        chk("R2", "immediate force_off", force_off, 1);
        chk("R2", "immediate tmr_rst", tmr_rst, 1);
        #0.5;
        tick(3);
        chk("R6", "ovc irq", sd_irq, 1);
        chk("R7", "cause ovc", sd_cause, 2);
        ovc_flag = 1'b0;
        tick(2);
        do_clear();
        chk("R5", "ovc cleared", force_off, 0);
    endtask

    task automatic t_sw();
        sw_halt_wr = 1'b1;
        chk("R3", "not yet off", force_off, 0);
        tick(); sw_halt_wr = 1'b0;
        chk("R3", "sw force_off", force_off, 1);
        chk("R6", "sw irq", sd_irq, 1);
        chk("R7", "cause sw", sd_cause, 3);
        tick();
        chk("R6", "sw irq ends", sd_irq, 0);
        chk("R4", "sw held", force_off, 1);
        ovc_flag = 1'b1;
        tick(3);
        chk("R6", "irq again while halted", sd_irq, 1);
        chk("R7", "cause ovc while halted", sd_cause, 2);
        ovc_flag = 1'b0;
        tick(2);
        do_clear();
        chk("R5", "sw cleared", force_off, 0);
    endtask

    task automatic t_same_cycle();
        sw_halt_wr = 1'b1; tick(); sw_halt_wr = 1'b0;
        tick();
        sw_halt_wr = 1'b1; sw_clear_wr = 1'b1;
        tick();
        sw_halt_wr = 1'b0; sw_clear_wr = 1'b0;
        chk("R9", "clear with halt ignored", force_off, 1);
        chk("R9", "irq on coincident halt", sd_irq, 1);
        do_clear();
        chk("R5", "later clear accepted", force_off, 0);
        trip_n = 1'b0;
        tick(2);
        sw_halt_wr = 1'b1;
        tick();
        sw_halt_wr = 1'b0;
        chk("R7", "trip outranks sw", sd_cause, 1);
        chk("R6", "coincident irq", sd_irq, 1);
        tick();
        chk("R6", "single irq", sd_irq, 0);
        trip_n = 1'b1;
        tick(2);
        do_clear();
        chk("R5", "final clear", force_off, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_stopped_clock();
        tick(2);
        t_trip();
        tick(2);
        t_ovc();
        tick(2);
        t_sw();
        tick(2);
        t_same_cycle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule